// File: doc/BRIEF.md
# Staggered Stage Evaluate Sequencer

This block produces the evaluate enables for a datapath that is built as a chain of dynamic stages. The first stage decodes and selects. Five carry-save rows follow it, and a final carry-propagate stage closes the chain. A stage must start evaluating only after its inputs have settled. The block therefore raises the enables one after another. A fixed number of fast-clock ticks separates each enable from the one before it.

The main clock phase arrives as a level on `eval_phase`, where high means the evaluate half and low means the precharge half. When the block samples `eval_phase` high, it raises the front-stage enable and then walks down the chain. When it samples `eval_phase` low, it drops the enables in the same order and with the same spacing. Because of this, the stages never all return to precharge on one tick, and the supply current is spread over time.

If the phase drops part way through the rise, the stages that have not yet evaluated stay low. The release then covers only the stages that had risen. A new evaluation starts only after the release has finished. `eval_phase` must be synchronous to `clk`. There is no data stream on this block, so none of its pins use a handshake.

Top module: `stagger_eval_seq`

## Requirements
- R1: While `rst_n` is low, every bit of `stage_en` is 0, which is precharge. After reset, every bit stays 0 until `eval_phase` is sampled high.
- R2: From the all-released state, bit 0 of `stage_en` (the front stage) rises at the first clock edge that samples `eval_phase` high.
- R3: While `eval_phase` stays high, bit k (k = 1 to 6) rises exactly k*STAGE_GAP ticks after bit 0 rose. Bits 1 to 5 are carry-save rows 1 to 5 and bit 6 is the carry-propagate stage, so the bits rise in ascending order. Each bit then stays high while the phase stays high.
- R4: At the first edge that samples `eval_phase` low, bit 0 falls. Each risen bit k then falls exactly STAGE_GAP ticks after bit k-1 fell. After the last risen bit has fallen, all bits are 0.
- R5: A bit that has not risen by the time `eval_phase` is sampled low never rises during that evaluation. This includes a bit whose rise falls due on the same edge that samples the phase low.
- R6: No two bits of `stage_en` change on the same clock edge.
- R7: A high `eval_phase` during a release is ignored until every bit is 0. Bit 0 then rises at the next edge that samples `eval_phase` high.
- R8: An evaluate phase that lasts one tick raises only bit 0, and bit 0 falls again on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that counts the delay ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_phase | input | 1 | Main phase: 1 for the evaluate half, 0 for the precharge half, synchronous to `clk` |
| stage_en | output | DOWN_STAGES+1 | Evaluate enables: bit 0 is the front stage, bits 1 and up are the downstream stages in chain order |

## Verification
Every enable is a register. Bit 0 therefore changes on the edge that samples the phase change. Bit k changes k*STAGE_GAP edges after that, for both the rise and the fall. A high phase that arrives during a release takes effect only on the edge after the last bit has fallen. The bench drives `eval_phase` on falling clock edges and logs the cycle number of every enable change at the next falling edge. Each scenario task then compares those logged cycles against values it works out from the tick at which it drove the phase.

// File: rtl/stagger_seq_pkg.sv
package stagger_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RISE = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_FALL = 2'd3
  } sq_state_e;

endpackage

// File: rtl/stagger_gap_timer.sv
module stagger_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int TW = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [TW-1:0] LAST = TW'(GAP - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/stagger_seq_ctrl.sv
module stagger_seq_ctrl
  import stagger_seq_pkg::*;
#(
  parameter int LANES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase,
  input  logic             expired,
  output logic             restart,
  output logic [LANES-1:0] set_vec,
  output logic [LANES-1:0] clr_vec
);
  localparam int IW = $clog2(LANES + 1);
  localparam logic [IW-1:0] ONE     = IW'(1);
  localparam logic [IW-1:0] TOP_IDX = IW'(LANES - 1);
  localparam logic [IW-1:0] ALL_UP  = IW'(LANES);

  sq_state_e     st_q, st_d;
  logic [IW-1:0] up_q, up_d;
  logic [IW-1:0] dn_q, dn_d;
  logic [IW-1:0] lim_q, lim_d;
  logic [IW-1:0] fire_idx;
  logic          fire_set, fire_clr;

  always_comb begin
    st_d     = st_q;
    up_d     = up_q;
    dn_d     = dn_q;
    lim_d    = lim_q;
    fire_idx = '0;
    fire_set = 1'b0;
    fire_clr = 1'b0;
    restart  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (phase) begin
          fire_set = 1'b1;
          restart  = 1'b1;
          up_d     = ONE;
          st_d     = SQ_RISE;
        end
      end
      SQ_RISE: begin
        if (!phase) begin
          fire_clr = 1'b1;
          restart  = 1'b1;
          dn_d     = ONE;
          lim_d    = up_q;
          st_d     = (up_q == ONE) ? SQ_IDLE : SQ_FALL;
        end else if (expired) begin
          fire_set = 1'b1;
          fire_idx = up_q;
          restart  = 1'b1;
          if (up_q == TOP_IDX) st_d = SQ_HOLD;
          else                 up_d = up_q + ONE;
        end
      end
      SQ_HOLD: begin
        if (!phase) begin
          fire_clr = 1'b1;
          restart  = 1'b1;
          dn_d     = ONE;
          lim_d    = ALL_UP;
          st_d     = SQ_FALL;
        end
      end
      SQ_FALL: begin
        if (expired) begin
          fire_clr = 1'b1;
          fire_idx = dn_q;
          restart  = 1'b1;
          if (dn_q + ONE == lim_q) st_d = SQ_IDLE;
          else                     dn_d = dn_q + ONE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      set_vec[i] = fire_set && (fire_idx == IW'(i));
      clr_vec[i] = fire_clr && (fire_idx == IW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      up_q  <= '0;
      dn_q  <= '0;
      lim_q <= '0;
    end else begin
      st_q  <= st_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/stagger_enable_bank.sv
module stagger_enable_bank #(
  parameter int LANES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] set_vec,
  input  logic [LANES-1:0] clr_vec,
  output logic [LANES-1:0] en
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en[g] <= 1'b0;
      else if (set_vec[g]) en[g] <= 1'b1;
      else if (clr_vec[g]) en[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/stagger_eval_seq.sv
module stagger_eval_seq #(
  parameter int DOWN_STAGES = 6,
  parameter int STAGE_GAP   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_phase,
  output logic [DOWN_STAGES:0] stage_en
);
  localparam int LANES = DOWN_STAGES + 1;

  logic             restart;
  logic             expired;
  logic [LANES-1:0] set_vec;
  logic [LANES-1:0] clr_vec;

  stagger_gap_timer #(.GAP(STAGE_GAP)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expired (expired)
  );

  stagger_seq_ctrl #(.LANES(LANES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (eval_phase),
    .expired (expired),
    .restart (restart),
    .set_vec (set_vec),
    .clr_vec (clr_vec)
  );

  stagger_enable_bank #(.LANES(LANES)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en      (stage_en)
  );
endmodule

// File: rtl/stagger_eval_seq_chk.sv
module stagger_eval_seq_chk #(
  parameter int LANES = 7,
  parameter int GAP   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_phase,
  input logic [LANES-1:0] stage_en
);
  localparam int AW = $clog2(GAP + 2);
  localparam logic [AW-1:0] AGE_MAX = AW'(GAP + 1);

  logic [LANES-1:0] prev_en;
  logic [AW-1:0]    age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en <= '0;
      age     <= '0;
    end else begin
      prev_en <= stage_en;
      if (stage_en != prev_en) age <= AW'(1);
      else if (age != AGE_MAX) age <= age + AW'(1);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (stage_en == '0);
    end
  end

  a_r6_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_en ^ $past(stage_en)) <= 1);

  // R3 and R4: every downstream change follows the previous change by GAP ticks
  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_en != prev_en) && (stage_en[0] == prev_en[0])) |-> (age == AW'(GAP)));

  a_r7_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_en[0]) |-> ($past(stage_en[LANES-1:1]) == '0));

  for (genvar k = 1; k < LANES; k++) begin : g_order
    a_r3_rise_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_en[k]) |-> (stage_en[k-1] && $past(stage_en[k-1])));
    a_r4_fall_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stage_en[k]) |-> !stage_en[k-1]);
    a_r5_no_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_en[k]) |-> $past(eval_phase));
  end
endmodule

bind stagger_eval_seq stagger_eval_seq_chk #(.LANES(DOWN_STAGES + 1), .GAP(STAGE_GAP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_phase (eval_phase),
  .stage_en   (stage_en)
);

// File: tb/stagger_eval_seq_tb_top.sv
`timescale 1ns/1ps
module stagger_eval_seq_tb_top;
  localparam int DOWN = 6;
  localparam int GAP  = 4;
  localparam int L    = DOWN + 1;
  localparam int SETTLE = L * GAP + 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         eval_phase = 1'b0;
  logic [L-1:0] stage_en;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int multi = 0;
  int rise_t [L];
  int fall_t [L];
  int rise_n [L];
  int fall_n [L];
  logic [L-1:0] prev_s = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stagger_eval_seq #(.DOWN_STAGES(DOWN), .STAGE_GAP(GAP)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_phase (eval_phase),
    .stage_en   (stage_en)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < L; k++) begin
        if (stage_en[k] && !prev_s[k]) begin rise_t[k] = cyc; rise_n[k]++; end
        if (!stage_en[k] && prev_s[k]) begin fall_t[k] = cyc; fall_n[k]++; end
      end
      if ($countones(stage_en ^ prev_s) > 1) multi++;
    end
    prev_s = stage_en;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int k = 0; k < L; k++) begin
      rise_t[k] = -1; fall_t[k] = -1; rise_n[k] = 0; fall_n[k] = 0;
    end
  endtask

  task automatic drive(input logic v, output int t);
    @(negedge clk);
    eval_phase = v;
    t = cyc + 1;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "enables in reset", int'(stage_en), 0);
    rst_n = 1'b1;
    settle(5);
    chk("R1", "enables after reset", int'(stage_en), 0);
  endtask

  task automatic t_full();
    int t0, d;
    clear_log();
    drive(1'b1, t0);
    settle(SETTLE);
    chk("R2", "front rise tick", rise_t[0], t0);
    for (int k = 1; k < L; k++) begin
      chk("R3", $sformatf("stage %0d rise tick", k), rise_t[k], t0 + k * GAP);
      chk("R3", $sformatf("stage %0d rise count", k), rise_n[k], 1);
    end
    chk("R3", "all held high", int'(stage_en), (1 << L) - 1);
    drive(1'b0, d);
    settle(SETTLE);
    for (int k = 0; k < L; k++)
      chk("R4", $sformatf("stage %0d fall tick", k), fall_t[k], d + k * GAP);
    chk("R4", "all released", int'(stage_en), 0);
  endtask

  task automatic t_trunc(string req, int hold);
    int t0, d, n_up;
    n_up = (hold - 1) / GAP + 1;
    clear_log();
    drive(1'b1, t0);
    repeat (hold - 1) @(negedge clk);
    drive(1'b0, d);
    settle(SETTLE);
    chk(req, "drop tick", d, t0 + hold);
    for (int k = 0; k < L; k++) begin
      chk(req, $sformatf("hold %0d stage %0d rises", hold, k), rise_n[k], (k < n_up) ? 1 : 0);
      if (k < n_up)
        chk("R4", $sformatf("hold %0d stage %0d fall tick", hold, k), fall_t[k], d + k * GAP);
    end
    chk(req, "all released", int'(stage_en), 0);
  endtask

  task automatic t_restart();
    int t0, d, tr;
    clear_log();
    drive(1'b1, t0);
    settle(SETTLE);
    drive(1'b0, d);
    repeat (2) @(negedge clk);
    drive(1'b1, tr);
    settle(SETTLE + GAP * DOWN);
    chk("R7", "front rise count", rise_n[0], 2);
    chk("R7", "restart tick", rise_t[0], d + DOWN * GAP + 1);
    chk("R7", "last release tick", fall_t[L-1], d + DOWN * GAP);
    drive(1'b0, d);
    settle(SETTLE);
    chk("R7", "released after restart", int'(stage_en), 0);
  endtask

  initial begin
    clear_log();
    t_reset();
    t_full();
    t_trunc("R5", 9);
    t_trunc("R5", 8);
    t_trunc("R8", 1);
    t_restart();
    chk("R6", "edges with more than one change", multi, 0);
    report();
  end

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule